// File: doc/BRIEF.md
# Configurable GPIO Function Router

This block routes six general-purpose pins of a power-management controller to their jobs. Each pin is set to one of four modes. An off pin drives nothing. A rail-enable pin is an input that switches a chosen group of supply rails. A power-good pin is an output that reports whether a chosen group of rails is in regulation. A fault pin is an output that reports a single selected fault or warning source. There are five rails: four buck controllers and one standby regulator. Each pin also has a polarity bit, and that bit inverts the pin whether it is an input or an output.

The host sets up the block through a plain register write port. It can also force rail enables directly through a host enable register, and the result is ORed with the pin requests. When the shared serial bus takes two pins, the polarity bits of those two pins are locked. The power-good level of every rail is also copied into a status output.

Top module: `gpio_rtr`

## Requirements
- R1: During and after reset, all pins are off (pin_oe and pin_out all 0), all polarity bits are 0 and rail_en is 0.
- R2: A write to address 6 loads polarity bits [5:0]. Bit n inverts pin n, both on the input path of a rail-enable pin and on the output of a power-good or fault pin.
- R3: While bus_mode is 1, a polarity write leaves bits 5 and 4 unchanged and still loads bits 3:0.
- R4: A write to address n (0..5) sets up pin n. Bits [1:0] are the mode (0 off, 1 rail enable, 2 power-good, 3 fault). Bits [6:2] are the rail mask: bit 2 is buck 1, bit 5 is buck 4, bit 6 is standby, and these map to rail_en bits 0..4. Bits [11:7] are the fault index. An off pin or a rail-enable pin keeps pin_oe=0 and pin_out=0, and an off pin has no effect on rail_en.
- R5: When a rail-enable pin becomes asserted (after polarity), every rail in its mask turns on. The rails turn off when the pin de-asserts. rail_en changes three clock edges after pin_in changes: two synchronizer stages and one output register.
- R6: A write to address 7 loads the host enables [4:0]. Each rail_en bit is the OR of its host enable and every asserted rail-enable pin whose mask includes that rail.
- R7: A power-good pin drives pin_oe=1. Its pre-polarity value is 1 only when its mask is non-empty and every masked rail has rail_pg=1. The output is registered, so it takes one edge.
- R8: A fault pin drives pin_oe=1 and outputs fault_src[index] through one register. The index values are 0-3 overcurrent fault ch1-4, 4-7 overcurrent warning ch1-4, 8-11 overvoltage fault ch1-4, 12-13 undervoltage-lockout fault on inputs 1-2, 14-15 undervoltage-lockout warning on inputs 1-2, 16 over-temperature fault and 17 over-temperature warning. Indices 18-31 give 0.
- R9: pg_status equals rail_pg delayed by one clock.
- R10: Writes to addresses 8-15 change no configuration, so the outputs stay as they were.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_mode | input | 1 | Serial bus owns pins 4 and 5; locks their polarity bits |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 12 | Register write data |
| pin_in | input | 6 | Pin input levels (asynchronous) |
| rail_pg | input | 5 | Per-rail in-regulation flags |
| fault_src | input | 18 | Fault and warning sources, indexed as in R8 |
| pin_out | output | 6 | Registered pin output levels |
| pin_oe | output | 6 | Registered pin output enables |
| rail_en | output | 5 | Registered rail enables |
| pg_status | output | 5 | Registered power-good status |

## Verification
The hardest case to reach from the ports is the polarity lock. A polarity bit cannot be read back, so the only way to see a lock is through a pin whose behaviour depends on that bit. The stimulus therefore first sets up pin 5 as a rail-enable input held low. It then writes polarity with bits 5 and 4 set while bus_mode is 1, and checks that rail_en keeps the mapped rail off while a bit-0 inversion still takes effect on pin 0. It repeats the write with bus_mode at 0 and shows the rail turning on. The rail-enable latency is also checked edge by edge, so that the synchronizer depth is pinned down.

// File: rtl/gpio_rtr_pkg.sv
package gpio_rtr_pkg;
  localparam int RAIL_N = 5;
  localparam int SEL_W  = 5;
  localparam int CFG_W  = 2 + RAIL_N + SEL_W;

  typedef enum logic [1:0] {
    PM_OFF    = 2'd0,
    PM_RAILEN = 2'd1,
    PM_PGOOD  = 2'd2,
    PM_FAULT  = 2'd3
  } pin_mode_e;

  typedef struct packed {
    logic [SEL_W-1:0]  fsel;
    logic [RAIL_N-1:0] rmask;
    pin_mode_e         mode;
  } pin_cfg_t;
endpackage

// File: rtl/gpio_rtr_sync.sv
module gpio_rtr_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else if (s == 0) stg[s] <= d;
        else stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_rtr_regs.sv
module gpio_rtr_regs
  import gpio_rtr_pkg::*;
#(
  parameter int NPINS   = 6,
  parameter int AW      = 4,
  parameter int LOCK_LO = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         bus_mode,
  input  logic                         wr_en,
  input  logic [AW-1:0]                wr_addr,
  input  logic [CFG_W-1:0]             wr_data,
  output pin_cfg_t [NPINS-1:0]         cfg,
  output logic [NPINS-1:0]             pol,
  output logic [RAIL_N-1:0]            host_en
);
  localparam logic [AW-1:0] POL_A  = AW'(NPINS);
  localparam logic [AW-1:0] HOST_A = AW'(NPINS + 1);

  generate
    for (genvar p = 0; p < NPINS; p++) begin : g_cfg
      always_ff @(posedge clk) begin
        if (rst) cfg[p] <= '{fsel: '0, rmask: '0, mode: PM_OFF};
        else if (wr_en && wr_addr == AW'(p)) cfg[p] <= pin_cfg_t'(wr_data);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      pol <= '0;
    end else if (wr_en && wr_addr == POL_A) begin
      for (int i = 0; i < NPINS; i++)
        if (!(bus_mode && i >= LOCK_LO)) pol[i] <= wr_data[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) host_en <= '0;
    else if (wr_en && wr_addr == HOST_A) host_en <= wr_data[RAIL_N-1:0];
  end

  AST_POL_LOCK: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == POL_A && bus_mode) |=> pol[NPINS-1:LOCK_LO] == $past(pol[NPINS-1:LOCK_LO])); // R3

  AST_UNMAPPED_WR: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr > HOST_A) |=> ($stable(pol) && $stable(host_en) && $stable(cfg))); // R10
endmodule

// File: rtl/gpio_rtr_pin.sv
module gpio_rtr_pin
  import gpio_rtr_pkg::*;
#(
  parameter int NFSRC = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  pin_cfg_t          cfg,
  input  logic              pol,
  input  logic              sync_in,
  input  logic [RAIL_N-1:0] rail_pg,
  input  logic [NFSRC-1:0]  fault_src,
  output logic [RAIL_N-1:0] rail_req,
  output logic              pin_out,
  output logic              pin_oe
);
  logic pg_ok, flt, raw, drive;

  assign rail_req = (cfg.mode == PM_RAILEN && (sync_in ^ pol)) ? cfg.rmask : '0;
  assign pg_ok    = (|cfg.rmask) && (&(rail_pg | ~cfg.rmask));

  always_comb begin
    flt = 1'b0;
    for (int i = 0; i < NFSRC; i++)
      if (cfg.fsel == SEL_W'(i)) flt = fault_src[i];
  end

  always_comb begin
    unique case (cfg.mode)
      PM_PGOOD: begin raw = pg_ok; drive = 1'b1; end
      PM_FAULT: begin raw = flt;   drive = 1'b1; end
      default:  begin raw = 1'b0;  drive = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_out <= 1'b0;
      pin_oe  <= 1'b0;
    end else begin
      pin_out <= drive & (raw ^ pol);
      pin_oe  <= drive;
    end
  end

  AST_QUIET_INPUT: assert property (@(posedge clk) disable iff (rst)
    (cfg.mode == PM_OFF || cfg.mode == PM_RAILEN) |=> (!pin_oe && !pin_out)); // R4

  AST_FAULT_DRIVES: assert property (@(posedge clk) disable iff (rst)
    (cfg.mode == PM_FAULT) |=> pin_oe); // R8

  AST_PG_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (cfg.mode == PM_PGOOD && cfg.rmask == '0) |=> (pin_out == $past(pol))); // R7
endmodule

// File: rtl/gpio_rtr.sv
module gpio_rtr
  import gpio_rtr_pkg::*;
#(
  parameter int NPINS   = 6,
  parameter int AW      = 4,
  parameter int NFSRC   = 18,
  parameter int SYNC_N  = 2,
  parameter int LOCK_LO = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_mode,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [CFG_W-1:0]  wr_data,
  input  logic [NPINS-1:0]  pin_in,
  input  logic [RAIL_N-1:0] rail_pg,
  input  logic [NFSRC-1:0]  fault_src,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic [RAIL_N-1:0] rail_en,
  output logic [RAIL_N-1:0] pg_status
);
  pin_cfg_t [NPINS-1:0] cfg;
  logic [NPINS-1:0]     pol;
  logic [RAIL_N-1:0]    host_en;
  logic [NPINS-1:0]     sync_in;
  logic [RAIL_N-1:0]    req [NPINS];
  logic [RAIL_N-1:0]    req_any;

  gpio_rtr_regs #(.NPINS(NPINS), .AW(AW), .LOCK_LO(LOCK_LO)) u_regs (
    .clk(clk), .rst(rst), .bus_mode(bus_mode), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .cfg(cfg), .pol(pol), .host_en(host_en)
  );

  gpio_rtr_sync #(.WIDTH(NPINS), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(sync_in)
  );

  generate
    for (genvar p = 0; p < NPINS; p++) begin : g_pin
      gpio_rtr_pin #(.NFSRC(NFSRC)) u_pin (
        .clk(clk), .rst(rst), .cfg(cfg[p]), .pol(pol[p]), .sync_in(sync_in[p]),
        .rail_pg(rail_pg), .fault_src(fault_src), .rail_req(req[p]),
        .pin_out(pin_out[p]), .pin_oe(pin_oe[p])
      );
    end
  endgenerate

  always_comb begin
    req_any = '0;
    for (int p = 0; p < NPINS; p++) req_any |= req[p];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rail_en   <= '0;
      pg_status <= '0;
    end else begin
      rail_en   <= host_en | req_any;
      pg_status <= rail_pg;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (rail_en == '0 && pin_oe == '0 && pin_out == '0)); // R1

  AST_HOST_OR: assert property (@(posedge clk) disable iff (rst)
    (|host_en) |=> ((rail_en & $past(host_en)) == $past(host_en))); // R6

  AST_PG_STATUS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pg_status == $past(rail_pg))); // R9
endmodule

// File: tb/gpio_rtr_bench.sv
module gpio_rtr_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_mode = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [11:0] wr_data = '0;
  logic [5:0]  pin_in = '0;
  logic [4:0]  rail_pg = '0;
  logic [17:0] fault_src = '0;
  logic [5:0]  pin_out, pin_oe;
  logic [4:0]  rail_en, pg_status;

  gpio_rtr u_gpio_rtr (
    .clk(clk), .rst(rst), .bus_mode(bus_mode), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pin_in(pin_in), .rail_pg(rail_pg), .fault_src(fault_src),
    .pin_out(pin_out), .pin_oe(pin_oe), .rail_en(rail_en), .pg_status(pg_status)
  );

  always #(CLK_P/2) clk = ~clk;

  typedef struct {
    int       due;
    int       sel;
    logic [7:0] m;
    logic [7:0] v;
    string    req;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] pick(int sel);
    case (sel)
      0: return {3'b0, rail_en};
      1: return {2'b0, pin_out};
      2: return {2'b0, pin_oe};
      default: return {3'b0, pg_status};
    endcase
  endfunction

  // monitor: pops due items and compares
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      logic [7:0] act;
      it = q.pop_front();
      act = pick(it.sel);
      total++;
      if ((act & it.m) !== (it.v & it.m)) begin
        bad++;
        $display("FAIL %s sel=%0d actual=%b expected=%b mask=%b", it.req, it.sel, act, it.v, it.m);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic push(int dly, int sel, logic [7:0] m, logic [7:0] v, string r);
    item_t it;
    it.due = cyc + dly; it.sel = sel; it.m = m; it.v = v; it.req = r;
    q.push_back(it);
  endtask

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
    tick(1);
  endtask

  task automatic wr(logic [3:0] a, logic [11:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    tick(1);
    wr_en = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    // R1 reset state while reset is held
    push(0, 0, 8'h1F, 8'h00, "R1");
    push(0, 2, 8'h3F, 8'h00, "R1");
    push(0, 1, 8'h3F, 8'h00, "R1");
    drain();
    rst = 1'b0;
    tick(1);

    // R9 status copy
    rail_pg = 5'b10110;
    push(1, 3, 8'h1F, 8'h16, "R9");
    drain();

    // R6 host enable alone
    wr(4'd7, 12'd5);
    push(1, 0, 8'h1F, 8'h05, "R6");
    drain();
    wr(4'd7, 12'd0);
    push(1, 0, 8'h1F, 8'h00, "R6");
    drain();

    // R5 rail enable with latency check
    wr(4'd0, 12'd13);          // pin0 rail enable, mask buck1|buck2
    tick(2);
    pin_in[0] = 1'b1;
    push(2, 0, 8'h1F, 8'h00, "R5");
    push(3, 0, 8'h1F, 8'h03, "R5");
    drain();
    pin_in[0] = 1'b0;
    push(2, 0, 8'h1F, 8'h03, "R5");
    push(3, 0, 8'h1F, 8'h00, "R5");
    drain();

    // R2 inverted input on pin1, mask standby
    wr(4'd6, 12'b000010);
    wr(4'd1, 12'd65);
    push(1, 0, 8'h1F, 8'h10, "R2");
    drain();
    // R6 OR of host and pins
    pin_in[0] = 1'b1;
    wr(4'd7, 12'b00100);
    push(3, 0, 8'h1F, 8'h17, "R6");
    drain();
    pin_in[1] = 1'b1;          // inverted pin de-asserts
    push(3, 0, 8'h1F, 8'h07, "R2");
    drain();
    pin_in[0] = 1'b0; pin_in[1] = 1'b0;
    wr(4'd7, 12'd0); wr(4'd0, 12'd0); wr(4'd1, 12'd0);
    tick(4);
    push(0, 0, 8'h1F, 8'h00, "R6");
    drain();

    // R7 power-good pin2 mask buck2|buck3
    wr(4'd2, 12'd26);
    push(1, 1, 8'h04, 8'h04, "R7");
    push(1, 2, 8'h04, 8'h04, "R7");
    drain();
    rail_pg = 5'b00100;
    push(1, 1, 8'h04, 8'h00, "R7");
    drain();
    rail_pg = 5'b11111;
    wr(4'd2, 12'd2);           // empty mask
    push(1, 1, 8'h04, 8'h00, "R7");
    drain();

    // R8 fault pin3
    wr(4'd3, 12'd1155);        // index 9: overvoltage fault ch2
    fault_src = 18'd1 << 9;
    push(1, 1, 8'h08, 8'h08, "R8");
    push(1, 2, 8'h08, 8'h08, "R8");
    drain();
    fault_src = ~(18'd1 << 9);
    push(1, 1, 8'h08, 8'h00, "R8");
    drain();
    fault_src = '1;
    wr(4'd3, 12'd2563);        // index 20: out of range
    push(1, 1, 8'h08, 8'h00, "R8");
    drain();
    fault_src = 18'd1 << 17;
    wr(4'd3, 12'd2179);        // index 17: over-temperature warning
    push(1, 1, 8'h08, 8'h08, "R8");
    drain();
    // R2 inverted output
    wr(4'd6, 12'b001010);
    push(1, 1, 8'h08, 8'h00, "R2");
    drain();

    // R3 polarity lock in bus mode
    wr(4'd0, 12'd13);
    wr(4'd5, 12'd33);          // pin5 rail enable, mask buck4
    bus_mode = 1'b1;
    wr(4'd6, 12'b111011);
    push(2, 0, 8'h1F, 8'h03, "R3");
    drain();
    bus_mode = 1'b0;
    wr(4'd6, 12'b111011);
    push(2, 0, 8'h1F, 8'h0B, "R3");
    drain();

    // R10 unmapped write
    wr(4'd9, 12'hFFF);
    push(2, 0, 8'h1F, 8'h0B, "R10");
    push(2, 2, 8'h3F, 8'h0C, "R10");
    push(2, 1, 8'h3F, 8'h00, "R10");
    drain();

    // R4 off pin ignored, rail-enable pin does not drive
    pin_in[4] = 1'b1;
    push(3, 0, 8'h1F, 8'h0B, "R4");
    push(3, 2, 8'h31, 8'h00, "R4");
    push(3, 1, 8'h31, 8'h00, "R4");
    drain();

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule